// File: doc/BRIEF.md
# Paged Program Counter Sequencer

This block is the program-flow unit of a small 8-bit microcontroller. It holds the 16-bit fetch address and updates it once per decoded instruction. The address can step forward by one, step by two when the current instruction asks for a skip, or branch. A branch target is the 2-bit ROM page register joined above a 14-bit operand. Calls push the return address onto an 8-entry return stack. Plain returns and interrupt returns pop it, and an interrupt return also sends a one-cycle pulse that sets the global interrupt enable.

The same block keeps a one-level shadow copy of the accumulator and the flag byte for fast context switching. Two flag bits, a watchdog-timeout flag and a power-down flag, are protected. They are not saved, and on a restore the caller's live values of those bits come back unchanged.

The decoder supplies one-hot-ish strobes, and the sequencer resolves any overlap by a fixed priority. Reset deassertion is expected to be synchronised to `clk` upstream.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst_n` is low, `pc_o` is 0 and `gie_set_o`, `stk_err_o`, `ctx_load_o`, `acc_rst_o` and `flags_rst_o` are all 0.
- R2: `step_i` alone advances `pc_o` by 1 on the next edge, and `step_i` with `skip_i` advances it by 2, both modulo 2^16. With no flow strobe, `pc_o` holds and `skip_i` alone has no effect.
- R3: `jmp_i` loads `pc_o` with `{page_i, target_i}` (page in bits 15:14, operand in bits 13:0).
- R4: `call_i` pushes `pc_o + 1` onto the return stack and loads `pc_o` exactly as a jump does.
- R5: `ret_i` loads `pc_o` with the most recently pushed address and leaves `gie_set_o` low.
- R6: `reti_i` pops the stack like `ret_i`, and `gie_set_o` is high for exactly the cycle after each accepted interrupt return.
- R7: The return stack holds 8 addresses. A push onto a full stack drops the oldest entry, and a pop from an empty stack returns the address popped last (0 after reset). Either event sets `stk_err_o`, which stays set until reset.
- R8: Flow strobes resolve by priority `reti_i` > `ret_i` > `call_i` > `jmp_i` > `step_i`, and only the winner touches the PC and the stack.
- R9: `ctx_push_i` stores `acc_i` and `flags_i` in a single shadow level, so a later push overwrites it. `ctx_pop_i` drives the saved values onto `acc_rst_o`/`flags_rst_o` on the next edge with `ctx_load_o` high for that cycle. When both strobes arrive together, the push is taken and no restore occurs.
- R10: Flag bits 7 (timeout) and 6 (power-down) are never saved. On a restore, those two bits of `flags_rst_o` equal `flags_i` as sampled at the pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Sequential advance |
| skip_i | input | 1 | Skip the next instruction (with step) |
| jmp_i | input | 1 | Jump strobe |
| call_i | input | 1 | Call strobe |
| ret_i | input | 1 | Return strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| target_i | input | 14 | Branch operand |
| page_i | input | 2 | ROM page register value |
| ctx_push_i | input | 1 | Save accumulator and flags |
| ctx_pop_i | input | 1 | Restore accumulator and flags |
| acc_i | input | 8 | Live accumulator |
| flags_i | input | 8 | Live flag byte |
| pc_o | output | 16 | Fetch address |
| gie_set_o | output | 1 | Global interrupt enable set pulse |
| stk_err_o | output | 1 | Sticky stack overflow/underflow flag |
| ctx_load_o | output | 1 | Restored context valid pulse |
| acc_rst_o | output | 8 | Restored accumulator |
| flags_rst_o | output | 8 | Restored flag byte |

## Verification
Every result of this block is due exactly one clock edge after the strobe that causes it: the new `pc_o`, the interrupt-enable pulse, the error flag, and the restored context with its load pulse. The bench drives strobes on a falling edge and updates its behavioural model at once. It then compares all outputs on the following falling edge, so each comparison sees the state after exactly one rising edge. The return stack is modelled as a bounded queue, which makes overflow and underflow expectations independent of the pointer structure in the design.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  typedef enum logic [2:0] {
    OP_HOLD,
    OP_NEXT,
    OP_SKIP,
    OP_JUMP,
    OP_CALL,
    OP_RET,
    OP_RETI
  } flow_op_e;
endpackage

// File: rtl/pcseq_decode.sv
module pcseq_decode
  import pcseq_pkg::*;
(
  input  logic     step_i,
  input  logic     skip_i,
  input  logic     jmp_i,
  input  logic     call_i,
  input  logic     ret_i,
  input  logic     reti_i,
  output flow_op_e op_o
);
  // Fixed priority: interrupt return, return, call, jump, step.
  always_comb begin
    if (reti_i)      op_o = OP_RETI;
    else if (ret_i)  op_o = OP_RET;
    else if (call_i) op_o = OP_CALL;
    else if (jmp_i)  op_o = OP_JUMP;
    else if (step_i) op_o = skip_i ? OP_SKIP : OP_NEXT;
    else             op_o = OP_HOLD;
  end
endmodule

// File: rtl/pcseq_stack.sv
module pcseq_stack #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] push_data_i,
  output logic [W-1:0] pop_data_o,
  output logic         err_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     ent_q [DEPTH];
  logic [PTR_W-1:0] wp_q, wp_n, wp_inc, wp_dec, rd_idx;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             err_q, err_n;
  logic             full, empty;

  assign full   = (cnt_q == CNT_W'(DEPTH));
  assign empty  = (cnt_q == '0);
  assign wp_inc = (wp_q == PTR_W'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
  assign wp_dec = (wp_q == '0) ? PTR_W'(DEPTH - 1) : wp_q - 1'b1;
  // An empty stack reads the slot that was popped last.
  assign rd_idx     = empty ? wp_q : wp_dec;
  assign pop_data_o = ent_q[rd_idx];
  assign err_o      = err_q;

  always_comb begin
    wp_n  = wp_q;
    cnt_n = cnt_q;
    err_n = err_q;
    if (push_i) begin
      wp_n = wp_inc;
      if (full) err_n = 1'b1;
      else      cnt_n = cnt_q + 1'b1;
    end else if (pop_i) begin
      if (empty) begin
        err_n = 1'b1;
      end else begin
        wp_n  = wp_dec;
        cnt_n = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      wp_q  <= wp_n;
      cnt_q <= cnt_n;
      err_q <= err_n;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic wr_en;
    assign wr_en = push_i && (wp_q == PTR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ent_q[g] <= '0;
      else if (wr_en) ent_q[g] <= push_data_i;
    end
  end
endmodule

// File: rtl/pcseq_ctx.sv
module pcseq_ctx #(
  parameter int          DW        = 8,
  parameter logic [7:0]  KEEP_MASK = 8'hC0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] flags_i,
  output logic [DW-1:0] acc_o,
  output logic [DW-1:0] flags_o,
  output logic          load_o
);
  localparam logic [DW-1:0] KEEP = DW'(KEEP_MASK);

  logic [DW-1:0] sh_acc_q, sh_fl_q, out_acc_q, out_fl_q;
  logic          ld_q, ld_n, sh_en, out_en;

  assign sh_en  = push_i;
  assign out_en = pop_i && !push_i;
  assign ld_n   = out_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_acc_q <= '0;
      sh_fl_q  <= '0;
    end else if (sh_en) begin
      sh_acc_q <= acc_i;
      sh_fl_q  <= flags_i & ~KEEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_acc_q <= '0;
      out_fl_q  <= '0;
    end else if (out_en) begin
      out_acc_q <= sh_acc_q;
      out_fl_q  <= (sh_fl_q & ~KEEP) | (flags_i & KEEP);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ld_q <= 1'b0;
    else        ld_q <= ld_n;
  end

  assign acc_o   = out_acc_q;
  assign flags_o = out_fl_q;
  assign load_o  = ld_q;
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcseq_pkg::*;
#(
  parameter int         PAGE_W    = 2,
  parameter int         OFS_W     = 14,
  parameter int         DATA_W    = 8,
  parameter int         STK_DEPTH = 8,
  parameter logic [7:0] KEEP_MASK = 8'hC0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      step_i,
  input  logic                      skip_i,
  input  logic                      jmp_i,
  input  logic                      call_i,
  input  logic                      ret_i,
  input  logic                      reti_i,
  input  logic [OFS_W-1:0]          target_i,
  input  logic [PAGE_W-1:0]         page_i,
  input  logic                      ctx_push_i,
  input  logic                      ctx_pop_i,
  input  logic [DATA_W-1:0]         acc_i,
  input  logic [DATA_W-1:0]         flags_i,
  output logic [PAGE_W+OFS_W-1:0]   pc_o,
  output logic                      gie_set_o,
  output logic                      stk_err_o,
  output logic                      ctx_load_o,
  output logic [DATA_W-1:0]         acc_rst_o,
  output logic [DATA_W-1:0]         flags_rst_o
);
  localparam int PC_W = PAGE_W + OFS_W;

  flow_op_e         op;
  logic [PC_W-1:0]  pc_q, pc_n, ret_addr, pop_addr;
  logic             gie_q, gie_n, stk_push, stk_pop;

  pcseq_decode u_dec (
    .step_i (step_i), .skip_i (skip_i), .jmp_i (jmp_i),
    .call_i (call_i), .ret_i  (ret_i),  .reti_i(reti_i),
    .op_o   (op)
  );

  assign stk_push = (op == OP_CALL);
  assign stk_pop  = (op == OP_RET) || (op == OP_RETI);
  assign ret_addr = pc_q + 1'b1;

  pcseq_stack #(.W(PC_W), .DEPTH(STK_DEPTH)) u_stk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (stk_push),
    .pop_i      (stk_pop),
    .push_data_i(ret_addr),
    .pop_data_o (pop_addr),
    .err_o      (stk_err_o)
  );

  always_comb begin
    pc_n  = pc_q;
    gie_n = 1'b0;
    unique case (op)
      OP_NEXT:           pc_n = pc_q + PC_W'(1);
      OP_SKIP:           pc_n = pc_q + PC_W'(2);
      OP_JUMP, OP_CALL:  pc_n = {page_i, target_i};
      OP_RET:            pc_n = pop_addr;
      OP_RETI: begin
        pc_n  = pop_addr;
        gie_n = 1'b1;
      end
      default:           pc_n = pc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      gie_q <= 1'b0;
    end else begin
      pc_q  <= pc_n;
      gie_q <= gie_n;
    end
  end

  assign pc_o      = pc_q;
  assign gie_set_o = gie_q;

  pcseq_ctx #(.DW(DATA_W), .KEEP_MASK(KEEP_MASK)) u_ctx (
    .clk    (clk),
    .rst_n  (rst_n),
    .push_i (ctx_push_i),
    .pop_i  (ctx_pop_i),
    .acc_i  (acc_i),
    .flags_i(flags_i),
    .acc_o  (acc_rst_o),
    .flags_o(flags_rst_o),
    .load_o (ctx_load_o)
  );
endmodule

// File: rtl/pcseq_checker.sv
module pcseq_checker #(
  parameter int         PAGE_W    = 2,
  parameter int         OFS_W     = 14,
  parameter int         DATA_W    = 8,
  parameter logic [7:0] KEEP_MASK = 8'hC0
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    step_i,
  input logic                    skip_i,
  input logic                    jmp_i,
  input logic                    call_i,
  input logic                    ret_i,
  input logic                    reti_i,
  input logic [OFS_W-1:0]        target_i,
  input logic [PAGE_W-1:0]       page_i,
  input logic                    ctx_push_i,
  input logic                    ctx_pop_i,
  input logic [DATA_W-1:0]       flags_i,
  input logic [PAGE_W+OFS_W-1:0] pc_o,
  input logic                    gie_set_o,
  input logic                    stk_err_o,
  input logic                    ctx_load_o,
  input logic [DATA_W-1:0]       flags_rst_o
);
  localparam logic [DATA_W-1:0] KEEP = DATA_W'(KEEP_MASK);

  // R2: plain step adds one
  a_r2_step_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !skip_i && !jmp_i && !call_i && !ret_i && !reti_i)
      |=> pc_o == $past(pc_o) + 1'b1);

  // R3: jump joins page and operand
  a_r3_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
    (jmp_i && !call_i && !ret_i && !reti_i)
      |=> pc_o == {$past(page_i), $past(target_i)});

  // R6: interrupt return gives the enable pulse
  a_r6_gie_on_reti: assert property (@(posedge clk) disable iff (!rst_n)
    reti_i |=> gie_set_o);

  // R5, R6: no pulse without an interrupt return
  a_r5_gie_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !reti_i |=> !gie_set_o);

  // R7: error flag is sticky
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    stk_err_o |=> stk_err_o);

  // R9: a lone pop produces the load pulse, a push suppresses it
  a_r9_load_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_pop_i && !ctx_push_i) |=> ctx_load_o);
  a_r9_push_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_push_i |=> !ctx_load_o);

  // R10: protected bits come from the live flags
  a_r10_keep_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_pop_i && !ctx_push_i) |=> (flags_rst_o & KEEP) == ($past(flags_i) & KEEP));
endmodule

bind pc_sequencer pcseq_checker #(
  .PAGE_W(PAGE_W), .OFS_W(OFS_W), .DATA_W(DATA_W), .KEEP_MASK(KEEP_MASK)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .step_i     (step_i),
  .skip_i     (skip_i),
  .jmp_i      (jmp_i),
  .call_i     (call_i),
  .ret_i      (ret_i),
  .reti_i     (reti_i),
  .target_i   (target_i),
  .page_i     (page_i),
  .ctx_push_i (ctx_push_i),
  .ctx_pop_i  (ctx_pop_i),
  .flags_i    (flags_i),
  .pc_o       (pc_o),
  .gie_set_o  (gie_set_o),
  .stk_err_o  (stk_err_o),
  .ctx_load_o (ctx_load_o),
  .flags_rst_o(flags_rst_o)
);

// File: tb/pc_sequencer_tb.sv
module pc_sequencer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_i = 0, skip_i = 0, jmp_i = 0, call_i = 0, ret_i = 0, reti_i = 0;
  logic [13:0] target_i = '0;
  logic [1:0]  page_i = '0;
  logic        ctx_push_i = 0, ctx_pop_i = 0;
  logic [7:0]  acc_i = '0, flags_i = '0;
  logic [15:0] pc_o;
  logic        gie_set_o, stk_err_o, ctx_load_o;
  logic [7:0]  acc_rst_o, flags_rst_o;

  always #5 clk = ~clk;

  pc_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .skip_i(skip_i), .jmp_i(jmp_i),
    .call_i(call_i), .ret_i(ret_i), .reti_i(reti_i), .target_i(target_i),
    .page_i(page_i), .ctx_push_i(ctx_push_i), .ctx_pop_i(ctx_pop_i),
    .acc_i(acc_i), .flags_i(flags_i), .pc_o(pc_o), .gie_set_o(gie_set_o),
    .stk_err_o(stk_err_o), .ctx_load_o(ctx_load_o), .acc_rst_o(acc_rst_o),
    .flags_rst_o(flags_rst_o)
  );

  // behavioural reference
  logic [15:0] m_pc, m_last;
  logic [15:0] m_q[$];
  logic        m_err, m_gie, m_ld;
  logic [7:0]  m_sh_acc, m_sh_fl, m_acc, m_fl;
  int          n_vec = 0, n_bad = 0;
  bit          done = 0;

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    check(tag, "pc", pc_o, m_pc);
    check(tag, "gie", gie_set_o, m_gie);
    check(tag, "err", stk_err_o, m_err);
    check(tag, "ld", ctx_load_o, m_ld);
    check(tag, "acc", acc_rst_o, m_acc);
    check(tag, "flags", flags_rst_o, m_fl);
  endtask

  task automatic model_reset();
    m_pc = 0; m_last = 0; m_q.delete(); m_err = 0; m_gie = 0; m_ld = 0;
    m_sh_acc = 0; m_sh_fl = 0; m_acc = 0; m_fl = 0;
  endtask

  // Called at a falling edge with inputs already set.
  task automatic tick(input string tag);
    m_gie = 0;
    if (reti_i || ret_i) begin
      if (m_q.size() > 0) m_last = m_q.pop_back();
      else m_err = 1;
      m_pc = m_last;
      m_gie = reti_i;
    end else if (call_i) begin
      m_q.push_back(m_pc + 16'd1);
      if (m_q.size() > 8) begin
        void'(m_q.pop_front());
        m_err = 1;
      end
      m_pc = {page_i, target_i};
    end else if (jmp_i) begin
      m_pc = {page_i, target_i};
    end else if (step_i) begin
      m_pc = m_pc + (skip_i ? 16'd2 : 16'd1);
    end
    if (ctx_push_i) begin
      m_sh_acc = acc_i; m_sh_fl = flags_i & 8'h3F; m_ld = 0;
    end else if (ctx_pop_i) begin
      m_acc = m_sh_acc; m_fl = m_sh_fl | (flags_i & 8'hC0); m_ld = 1;
    end else begin
      m_ld = 0;
    end
    @(negedge clk);
    compare(tag);
    step_i = 0; skip_i = 0; jmp_i = 0; call_i = 0; ret_i = 0; reti_i = 0;
    ctx_push_i = 0; ctx_pop_i = 0;
  endtask

  task automatic do_jump(input string tag, input logic [1:0] pg, input logic [13:0] tg);
    page_i = pg; target_i = tg; jmp_i = 1; tick(tag);
  endtask

  task automatic do_call(input string tag, input logic [1:0] pg, input logic [13:0] tg);
    page_i = pg; target_i = tg; call_i = 1; tick(tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1;
    @(negedge clk);
    compare("R1");

    // R2: hold, skip alone, steps, skip step
    tick("R2");
    skip_i = 1; tick("R2");
    repeat (3) begin step_i = 1; tick("R2"); end
    step_i = 1; skip_i = 1; tick("R2");

    // R3: jump forms address from page and operand
    do_jump("R3", 2'd2, 14'h1234);
    do_jump("R3", 2'd1, 14'h3FFF);
    // R2: wrap-around
    do_jump("R3", 2'd3, 14'h3FFF);
    step_i = 1; tick("R2");
    do_jump("R3", 2'd3, 14'h3FFF);
    step_i = 1; skip_i = 1; tick("R2");

    // R4, R5: call then return
    do_call("R4", 2'd1, 14'h0100);
    step_i = 1; tick("R2");
    ret_i = 1; tick("R5");

    // R6: nested calls unwound by interrupt returns
    do_call("R4", 2'd0, 14'h0200);
    do_call("R4", 2'd2, 14'h0300);
    do_call("R4", 2'd3, 14'h0400);
    reti_i = 1; tick("R6");
    reti_i = 1; tick("R6");
    ret_i = 1; tick("R5");
    tick("R6");

    // R8: priority among strobes
    do_call("R8", 2'd1, 14'h0010);
    page_i = 2'd2; target_i = 14'h0777;
    reti_i = 1; ret_i = 1; call_i = 1; jmp_i = 1; step_i = 1; tick("R8");
    page_i = 2'd0; target_i = 14'h0050; call_i = 1; jmp_i = 1; step_i = 1; tick("R8");
    page_i = 2'd3; target_i = 14'h0060; jmp_i = 1; step_i = 1; skip_i = 1; tick("R8");
    ret_i = 1; call_i = 1; tick("R8");

    // R9, R10: shadow context
    acc_i = 8'h5A; flags_i = 8'hFF; ctx_push_i = 1; tick("R9");
    acc_i = 8'hA5; flags_i = 8'h3C; ctx_push_i = 1; tick("R9");
    acc_i = 8'h00; flags_i = 8'h80; ctx_pop_i = 1; tick("R10");
    tick("R9");
    acc_i = 8'h11; flags_i = 8'hC3; ctx_push_i = 1; ctx_pop_i = 1; tick("R9");
    flags_i = 8'h40; ctx_pop_i = 1; tick("R10");
    flags_i = 8'h00; ctx_pop_i = 1; tick("R10");

    // R7: overflow, underflow, sticky error
    for (int i = 0; i < 9; i++) do_call("R7", 2'(i), 14'(16'h0A00 + i));
    for (int i = 0; i < 10; i++) begin ret_i = 1; tick("R7"); end
    step_i = 1; tick("R7");
    tick("R7");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule